// File: doc/BRIEF.md
# Pad Function Router

This block decides, for every pad of a pad ring of up to 128 pins, which agent drives it: a routable peripheral function, the general-purpose I/O logic, or the I/O co-processor. A per-pad route bit picks between the function mux (0) and local ownership (1). A second per-pad bit, written through a per-bit write mask, picks GPIO (1) or the co-processor (0) for pads under local ownership.

A set of routable peripheral functions each holds a 7-bit pad selector. Value 0 leaves the function unmapped. A value k in 1..64 steers it to pad k+7, so pads 8 to 71 are reachable. Values 65..127 also count as unmapped. Writing a mapping hands the target pad to the function mux at once. The block turns this state into per-pad owner selects, a per-pad function output enable and the number of the function on that pad, plus a decoded pad index for every function. When two functions claim one pad, the lower-numbered one wins, and a sticky flag records the clash until software reads it.

Software reaches the state through a flat word bus. The bus has a write strobe, a read strobe, a 5-bit word address, 32-bit write data and combinational read data. A read strobe on the status word clears the clash flag.

Top module: `pinmux_router`

## Requirements
- R1: After reset, every route bit, owner bit and function selector is 0 and the clash flag is clear. All pads are then in mux mode with no function mapped, and every output and every readable word is 0.
- R2: Word addresses 0 to NPINS/32-1 hold the route bits as plain 32-bit words, with pad p at word p/32, bit p%32. A write replaces the whole word, and a read returns it.
- R3: Word addresses 8 to 8+NPINS/16-1 hold the owner bits, with pad p at word 8+p/16. Bit p%16 is the value and bit 16+p%16 is its write enable, so a bit changes only when its enable is 1. A read returns the values in bits 15:0 and 0 in bits 31:16.
- R4: A pad whose route bit is 1 drives pad_gpio when its owner bit is 1 and pad_iop when its owner bit is 0. A pad whose route bit is 0 drives neither.
- R5: Function f sits in word 16+f/2. An even f uses value bits 6:0 with enable bits 22:16, and an odd f uses value bits 14:8 with enable bits 30:24. Each selector bit changes only where its enable bit is 1. A read returns both selectors, with all other bits 0.
- R6: fn_valid[f] is 1 exactly when selector f is in 1..64. fn_pad[7f+6:7f] is then the selector plus 7, and 0 otherwise.
- R7: A function write whose enable field is nonzero and whose resulting selector is in 1..64 clears the route bit of the target pad in the same clock edge. Owner bits are left alone. An unmapped result changes no route bit.
- R8: pad_fn_oe[p] is 1 only when the route bit of p is 0 and some valid function points at p. In that case pad_fn_sel for p carries the lowest such function number, and it is 0 otherwise.
- R9: The clash flag is set on any edge where two valid functions point at one pad. A read strobe on word 31 returns the flag in bit 0 and clears it on that edge, unless a clash is present on the same edge, in which case the flag stays set.
- R10: Reads of unmapped word addresses, and any read with the read strobe low, return 0. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears clash flag on word 31) |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| pad_gpio | output | NPINS | Pad owned by GPIO |
| pad_iop | output | NPINS | Pad owned by I/O co-processor |
| pad_fn_oe | output | NPINS | Pad driven by a routed function |
| pad_fn_sel | output | NPINS*SELW | Winning function number per pad |
| fn_valid | output | NFUNC | Function mapped to a pad |
| fn_pad | output | NFUNC*7 | Decoded pad index per function |

## Verification
Two pairs of actions can land on the same edge. The first pair is a status read that clears the clash flag while two selectors still point at one pad. The bench maps two functions to the same pad, reads the status word twice while the clash persists, then unmaps one function and reads twice more, expecting 1, 1, 1, 0. The second pair is a single function-word write that maps both of its functions, so two route bits are cleared on one edge while other route and owner bits must hold. A behavioural model in the bench tracks every write and read-clear and is compared with all outputs on every clock, under a long random phase of mixed route, owner, function and status accesses.

// File: rtl/pinmux_router.sv
module pinmux_router #(
  parameter int NPINS = 128,
  parameter int NFUNC = 8,
  localparam int SELW = (NFUNC > 1) ? $clog2(NFUNC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [4:0]              addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic [NPINS-1:0]        pad_gpio,
  output logic [NPINS-1:0]        pad_iop,
  output logic [NPINS-1:0]        pad_fn_oe,
  output logic [NPINS*SELW-1:0]   pad_fn_sel,
  output logic [NFUNC-1:0]        fn_valid,
  output logic [NFUNC*7-1:0]      fn_pad
);

  localparam int RWORDS = NPINS / 32;
  localparam int OWORDS = NPINS / 16;
  localparam int OBASE  = 8;
  localparam int FBASE  = 16;
  localparam int SADDR  = 31;
  localparam int PAD_LO = 8;
  localparam int KMAX   = 64;

  logic [NPINS-1:0]      route_q, route_d, own_q, own_d;
  logic [NFUNC-1:0][6:0] sel_q, sel_d, pad_idx;
  logic                  clash, clash_q;
  logic                  stat_rd;

  assign stat_rd = rd_en && int'(addr) == SADDR;

  always_comb begin
    for (int f = 0; f < NFUNC; f++) begin
      fn_valid[f] = sel_q[f] != 7'd0 && sel_q[f] <= 7'(KMAX);
      pad_idx[f]  = fn_valid[f] ? sel_q[f] + 7'(PAD_LO - 1) : 7'd0;
    end
  end
  assign fn_pad = pad_idx;

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NFUNC; i++)
      for (int j = i + 1; j < NFUNC; j++)
        if (fn_valid[i] && fn_valid[j] && pad_idx[i] == pad_idx[j]) clash = 1'b1;
  end

  always_comb begin
    logic [6:0] msk, nv;
    msk = '0;
    nv = '0;
    route_d = route_q;
    own_d = own_q;
    sel_d = sel_q;
    if (wr_en) begin
      for (int w = 0; w < RWORDS; w++)
        if (int'(addr) == w) route_d[w*32 +: 32] = wdata;
      for (int m = 0; m < OWORDS; m++)
        if (int'(addr) == OBASE + m)
          for (int i = 0; i < 16; i++)
            if (wdata[16+i]) own_d[m*16+i] = wdata[i];
      for (int f = 0; f < NFUNC; f++)
        if (int'(addr) == FBASE + f / 2) begin
          msk = wdata[16 + 8*(f%2) +: 7];
          nv = (sel_q[f] & ~msk) | (wdata[8*(f%2) +: 7] & msk);
          sel_d[f] = nv;
          if (msk != 7'd0 && nv != 7'd0 && nv <= 7'(KMAX))
            route_d[int'(nv) + PAD_LO - 1] = 1'b0;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      own_q   <= '0;
      sel_q   <= '0;
      clash_q <= 1'b0;
    end else begin
      route_q <= route_d;
      own_q   <= own_d;
      sel_q   <= sel_d;
      clash_q <= clash | (clash_q & ~stat_rd);
    end
  end

  assign pad_gpio = route_q & own_q;
  assign pad_iop  = route_q & ~own_q;

  always_comb begin
    logic            hit;
    logic [SELW-1:0] win;
    for (int p = 0; p < NPINS; p++) begin
      hit = 1'b0;
      win = '0;
      for (int f = NFUNC - 1; f >= 0; f--)
        if (fn_valid[f] && int'(pad_idx[f]) == p) begin
          hit = 1'b1;
          win = SELW'(f);
        end
      pad_fn_oe[p] = hit & ~route_q[p];
      pad_fn_sel[p*SELW +: SELW] = (hit & ~route_q[p]) ? win : '0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int w = 0; w < RWORDS; w++)
        if (int'(addr) == w) rdata = route_q[w*32 +: 32];
      for (int m = 0; m < OWORDS; m++)
        if (int'(addr) == OBASE + m) rdata[15:0] = own_q[m*16 +: 16];
      for (int f = 0; f < NFUNC; f++)
        if (int'(addr) == FBASE + f / 2) rdata[8*(f%2) +: 7] = sel_q[f];
      if (int'(addr) == SADDR) rdata[0] = clash_q;
    end
  end

  // R8
  fn_vs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_gpio | pad_iop) & pad_fn_oe) == '0);

  // R7
  map_clears_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == FBASE && wdata[22:16] == 7'h7F && wdata[6:0] == 7'd1)
    |=> !route_q[PAD_LO]);

  // R3
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == OBASE && wdata[31:16] == 16'h0) |=> $stable(own_q[15:0]));

  // R9
  clash_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clash_q && !stat_rd) |=> clash_q);

  // R9
  clash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !clash) |=> !clash_q);

  // R6
  fn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_valid[0] |-> (fn_pad[6:0] >= 7'd8 && fn_pad[6:0] <= 7'd71));

endmodule

// File: tb/sim_pinmux_router.sv
`timescale 1ns/1ps
module sim_pinmux_router;
  localparam int NPINS = 128;
  localparam int NFUNC = 8;
  localparam int SELW = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NPINS-1:0] pad_gpio, pad_iop, pad_fn_oe;
  logic [NPINS*SELW-1:0] pad_fn_sel;
  logic [NFUNC-1:0] fn_valid;
  logic [NFUNC*7-1:0] fn_pad;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  pinmux_router #(.NPINS(NPINS), .NFUNC(NFUNC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_gpio(pad_gpio), .pad_iop(pad_iop),
    .pad_fn_oe(pad_fn_oe), .pad_fn_sel(pad_fn_sel), .fn_valid(fn_valid), .fn_pad(fn_pad));

  bit [NPINS-1:0] m_route, m_own;
  int m_sel[NFUNC];
  bit m_clash;

  function automatic bit m_ok(int f);
    return m_sel[f] >= 1 && m_sel[f] <= 64;
  endfunction

  function automatic logic [31:0] m_rd(int a);
    logic [31:0] v;
    v = '0;
    if (!rd_en) return v;
    if (a < NPINS/32) begin
      for (int b = 0; b < 32; b++) v[b] = m_route[a*32+b];
    end else if (a >= 8 && a < 8 + NPINS/16) begin
      for (int b = 0; b < 16; b++) v[b] = m_own[(a-8)*16+b];
    end else if (a >= 16 && a < 16 + NFUNC/2) begin
      v[6:0] = 7'(m_sel[2*(a-16)]);
      v[14:8] = 7'(m_sel[2*(a-16)+1]);
    end else if (a == 31) v[0] = m_clash;
    return v;
  endfunction

  task automatic model_step();
    bit hit, clr;
    int a, f, mk, vl, nf;
    hit = 0;
    for (int i = 0; i < NFUNC; i++)
      for (int j = i + 1; j < NFUNC; j++)
        if (m_ok(i) && m_ok(j) && m_sel[i] == m_sel[j]) hit = 1;
    clr = rd_en && addr == 5'd31;
    if (wr_en) begin
      a = addr;
      if (a < NPINS/32) begin
        for (int b = 0; b < 32; b++) m_route[a*32+b] = wdata[b];
      end else if (a >= 8 && a < 8 + NPINS/16) begin
        for (int b = 0; b < 16; b++) if (wdata[16+b]) m_own[(a-8)*16+b] = wdata[b];
      end else if (a >= 16 && a < 16 + NFUNC/2) begin
        for (int s = 0; s < 2; s++) begin
          f = 2*(a-16) + s;
          mk = (wdata >> (16 + 8*s)) & 127;
          vl = (wdata >> (8*s)) & 127;
          nf = ((m_sel[f] & ~mk) | (vl & mk)) & 127;
          m_sel[f] = nf;
          if (mk != 0 && nf >= 1 && nf <= 64) m_route[nf+7] = 0;
        end
      end
    end
    m_clash = hit | (m_clash & !clr);
  endtask

  task automatic fail(string tag, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) fail(tag, act, exp);
  endtask

  task automatic compare();
    int bad, win;
    logic [31:0] ea, ee;
    bad = 0;
    for (int p = 0; p < NPINS; p++)
      if (pad_gpio[p] !== (m_route[p] & m_own[p]) || pad_iop[p] !== (m_route[p] & !m_own[p])) begin
        if (bad == 0) begin ea = {pad_gpio[p], pad_iop[p]}; ee = {m_route[p] & m_own[p], m_route[p] & !m_own[p]}; end
        bad++;
      end
    checks++;
    if (bad != 0) fail("R4 owner", ea, ee);
    bad = 0;
    for (int f = 0; f < NFUNC; f++)
      if (fn_valid[f] !== m_ok(f) || fn_pad[f*7 +: 7] !== (m_ok(f) ? 7'(m_sel[f] + 7) : 7'd0)) begin
        if (bad == 0) begin ea = {fn_valid[f], fn_pad[f*7 +: 7]}; ee = {m_ok(f), (m_ok(f) ? 7'(m_sel[f] + 7) : 7'd0)}; end
        bad++;
      end
    checks++;
    if (bad != 0) fail("R6 decode", ea, ee);
    bad = 0;
    for (int p = 0; p < NPINS; p++) begin
      win = -1;
      for (int f = NFUNC - 1; f >= 0; f--) if (m_ok(f) && m_sel[f] + 7 == p) win = f;
      if (win >= 0 && !m_route[p]) begin
        ee = {1'b1, 3'(win)};
      end else ee = 0;
      ea = {pad_fn_oe[p], pad_fn_sel[p*SELW +: SELW]};
      if (ea !== ee) bad++;
    end
    checks++;
    if (bad != 0) fail("R8 pad select", 32'(bad), 0);
    checks++;
    if (rdata !== m_rd(addr)) fail("R2/R3/R5/R9/R10 rdata", rdata, m_rd(addr));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_route = '0; m_own = '0; m_clash = 0;
      for (int f = 0; f < NFUNC; f++) m_sel[f] = 0;
    end else model_step();
    #3;
    if (cmp_on) compare();
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a[4:0]; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a[4:0];
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [31:0] fw(logic [6:0] em, logic [6:0] ev, logic [6:0] om, logic [6:0] ov);
    return {1'b0, om, 1'b0, em, 1'b0, ov, 1'b0, ev};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    #1;
    chk("R1 pad_fn_oe", 32'(pad_fn_oe != 0), 0);
    chk("R1 owners", 32'((pad_gpio | pad_iop) != 0), 0);
    chk("R1 fn_valid", 32'(fn_valid), 0);
    rd(0, d); chk("R1 route word", d, 0);
    rd(17, d); chk("R1 function word", d, 0);
    rd(31, d); chk("R1 status", d, 0);
    // R2
    wr(0, 32'h0000_FF00);
    rd(0, d); chk("R2 route readback", d, 32'h0000_FF00);
    #1 chk("R4 iop pad 8", 32'(pad_iop[8]), 1);
    // R3
    wr(8, 32'h0300_0300);
    rd(8, d); chk("R3 owner readback", d, 32'h0000_0300);
    wr(8, 32'h0000_0000);
    rd(8, d); chk("R3 unmasked write ignored", d, 32'h0000_0300);
    #1 chk("R4 gpio pad 8", 32'(pad_gpio[8]), 1);
    chk("R4 iop pad 10", 32'(pad_iop[10]), 1);
    // R7: two functions mapped by one write
    wr(16, fw(7'h7F, 7'd1, 7'h7F, 7'd2));
    rd(0, d); chk("R7 route bits 8,9 cleared", d, 32'h0000_FC00);
    rd(8, d); chk("R7 owner untouched", d, 32'h0000_0300);
    #1 chk("R8 pad 8 oe", 32'(pad_fn_oe[8]), 1);
    chk("R8 pad 9 sel", 32'(pad_fn_sel[9*SELW +: SELW]), 1);
    chk("R6 fn0 pad", 32'(fn_pad[6:0]), 8);
    rd(16, d); chk("R5 function readback", d, 32'h0000_0201);
    // R5 partial mask
    wr(16, fw(7'h01, 7'd0, 7'h00, 7'd0));
    rd(16, d); chk("R5 partial mask", d, 32'h0000_0200);
    #1 chk("R8 pad 8 released", 32'(pad_fn_oe[8]), 0);
    // R6 range
    wr(2, 32'hFFFF_FFFF);
    wr(17, fw(7'h7F, 7'd65, 7'h7F, 7'd64));
    rd(2, d); chk("R7 only pad 71 cleared", d, 32'hFFFF_FF7F);
    #1 chk("R6 value 65 unmapped", 32'(fn_valid[2]), 0);
    chk("R6 value 64 pad 71", 32'(fn_pad[3*7 +: 7]), 71);
    // R8 priority and R9 clash with same-edge clear
    wr(18, fw(7'h7F, 7'd12, 7'h7F, 7'd12));
    #1 chk("R8 lowest wins pad 19", 32'(pad_fn_sel[19*SELW +: SELW]), 4);
    rd(31, d); chk("R9 clash set", d, 1);
    rd(31, d); chk("R9 set wins over clear", d, 1);
    wr(18, fw(7'h00, 7'd0, 7'h7F, 7'd0));
    rd(31, d); chk("R9 sticky after unmap", d, 1);
    rd(31, d); chk("R9 cleared by read", d, 0);
    // R8 route bit blocks function
    wr(0, 32'h0008_FC00);
    #1 chk("R8 route=1 blocks oe", 32'(pad_fn_oe[19]), 0);
    chk("R4 iop pad 19", 32'(pad_iop[19]), 1);
    // R10
    wr(5, 32'hFFFF_FFFF);
    rd(5, d); chk("R10 unmapped read", d, 0);
    rd(0, d); chk("R10 unmapped write no effect", d, 32'h0008_FC00);
    // random phase, compared every clock against the model
    for (int n = 0; n < 3000; n++) begin
      int op, a;
      logic [6:0] v0, v1;
      op = $urandom % 8;
      if (op < 2) wr($urandom % 4, $urandom);
      else if (op < 4) wr(8 + $urandom % 8, $urandom);
      else if (op < 7) begin
        v0 = ($urandom % 3 == 0) ? 7'($urandom) : 7'(1 + $urandom % 16);
        v1 = ($urandom % 3 == 0) ? 7'($urandom) : 7'(1 + $urandom % 16);
        a = 16 + $urandom % 4;
        wr(a, fw(($urandom % 4 == 0) ? 7'($urandom) : 7'h7F, v0,
                 ($urandom % 4 == 0) ? 7'($urandom) : 7'h7F, v1));
      end else begin
        a = ($urandom % 2 == 0) ? 31 : int'($urandom % 32);
        rd(a, d);
      end
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule